// File: doc/BRIEF.md
# Interpolating TDC Timing Front End

This block is the clocked control section of an interpolating time-to-digital converter. Two asynchronous event inputs are routed through a swappable multiplexer onto a start path and a stop path. Each path drives a gate window for an external interpolator. The window opens the moment the event arrives. It closes on the second rising system-clock edge after the event, so the flop that first samples the event has a whole period to settle. A coarse counter counts whole clock periods from the end of the start window to the end of the stop window. The measured interval is then coarse + T1 − T2, where T1 and T2 are the interpolator codes.

After a measurement is read, the start and stop assignment flips, so that over pairs of measurements the mismatch between the two interpolators cancels. A calibration request drives a one-period window into both interpolators. When that result is read, it drives a two-period window into both. Downstream logic can derive the interpolator gains from these two known lengths. The external interpolators report completion through a ready input. Each result is held until it is acknowledged.

Top module: `tdc_frontend_ctl`

## Requirements
- R1: After reset, busy, result_valid, err, swap, cal_res and both gates are 0.
- R2: With swap=0, ev_a is the start path. A start rise in idle (the start input was low at the previous clock edge) raises gate_t1 at once. gate_t1 falls on the second rising clk edge after the rise.
- R3: gate_t2 opens at a stop-path rise during a measurement. It falls on the second rising clk edge after that rise.
- R4: When the stop event is d whole clock periods after the start event (same phase or later within the cycle), coarse reads d.
- R5: result_valid rises only after both windows have closed and ip_ready is seen high. It stays high until rd_ack is sampled high.
- R6: Reading a measurement result toggles swap. With swap=1, ev_b drives the start path (gate_t1) and ev_a drives the stop path (gate_t2). swap changes at no other time.
- R7: When cal_req is taken in idle, both gates are high together for exactly one clock period, and the result carries cal_res=1 and cal_long=0. Acknowledging that result drives both gates high for exactly two periods, and that result carries cal_long=1. Calibration does not change swap.
- R8: If the coarse count would pass 2^CW−1, err is set and the block returns to idle without a result. This covers a stop that arrives too late or never arrives. err clears when the next measurement or calibration starts.
- R9: A stop that closes exactly 2^CW−1 periods after the start gives a valid result with coarse = 2^CW−1 and no err.
- R10: While a result is waiting to be read, event inputs are ignored. No gate opens and coarse does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_a | input | 1 | Event input A (start when swap=0) |
| ev_b | input | 1 | Event input B (stop when swap=0) |
| cal_req | input | 1 | Calibration request, taken in idle |
| ip_ready | input | 1 | Interpolators have finished converting |
| rd_ack | input | 1 | Result has been read |
| gate_t1 | output | 1 | Start-path interpolator window |
| gate_t2 | output | 1 | Stop-path interpolator window |
| coarse | output | CW | Whole periods between window ends |
| swap | output | 1 | Channel assignment used for the current result |
| cal_res | output | 1 | Current result is a calibration step |
| cal_long | output | 1 | Calibration step used the two-period window |
| busy | output | 1 | Measurement or calibration in progress |
| result_valid | output | 1 | Result held for reading |
| err | output | 1 | Last measurement overflowed the coarse counter |

## Verification
The bench places event edges both before and after the falling clock edge. A design that closed a window on the first edge, or on the third, would show a window one sampled period too short or too long. Intervals of zero periods and of exactly the counter maximum are driven directly. An off-by-one in the counting edges or in the overflow test would give a wrong coarse value, or a false or missing err. Measurements are taken in long alternating runs, so a swap that does not toggle, or that toggles on calibration, would send an event to the wrong gate. Event pulses arrive while a result waits. Calibration windows are timed period by period, so a gate one cycle too long or too short in either step is caught.

// File: rtl/tdc_frontend_ctl.sv
module tdc_frontend_ctl #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_a,
  input  logic          ev_b,
  input  logic          cal_req,
  input  logic          ip_ready,
  input  logic          rd_ack,
  output logic          gate_t1,
  output logic          gate_t2,
  output logic [CW-1:0] coarse,
  output logic          swap,
  output logic          cal_res,
  output logic          cal_long,
  output logic          busy,
  output logic          result_valid,
  output logic          err
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  typedef enum logic [2:0] {IDLE, MEAS, CALG, WAITIP, DONE} st_t;
  st_t st;

  logic s_in, p_in, arm, run, q1s, q2s, q1p, q2p, ccnt;

  assign s_in = swap ? ev_b : ev_a;
  assign p_in = swap ? ev_a : ev_b;
  assign run  = (st == MEAS) || (st == IDLE && arm && s_in);

  assign gate_t1      = (st == CALG) || (run && s_in && !q2s);
  assign gate_t2      = (st == CALG) || (run && p_in && !q2p);
  assign busy         = (st != IDLE);
  assign result_valid = (st == DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm <= 1'b0;
      q1s <= 1'b0; q2s <= 1'b0; q1p <= 1'b0; q2p <= 1'b0;
    end else begin
      arm <= !s_in;
      q1s <= run && s_in;
      q2s <= run && q1s;
      q1p <= run && p_in;
      q2p <= run && q1p;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= IDLE;
      coarse   <= '0;
      swap     <= 1'b0;
      cal_res  <= 1'b0;
      cal_long <= 1'b0;
      ccnt     <= 1'b0;
      err      <= 1'b0;
    end else begin
      case (st)
        IDLE: begin
          coarse <= '0;
          if (arm && s_in) begin
            st      <= MEAS;
            err     <= 1'b0;
            cal_res <= 1'b0;
          end else if (cal_req) begin
            st       <= CALG;
            err      <= 1'b0;
            cal_res  <= 1'b1;
            cal_long <= 1'b0;
            ccnt     <= 1'b0;
          end
        end
        MEAS: begin
          if (q2s && q2p) st <= WAITIP;
          else if (q2s) begin
            if (coarse == CMAX) begin
              err <= 1'b1;
              st  <= IDLE;
            end else coarse <= coarse + 1'b1;
          end
        end
        CALG: begin
          if (ccnt == cal_long) st <= WAITIP;
          else ccnt <= 1'b1;
        end
        WAITIP: if (ip_ready) st <= DONE;
        DONE: begin
          if (rd_ack) begin
            if (cal_res && !cal_long) begin
              cal_long <= 1'b1;
              ccnt     <= 1'b0;
              st       <= CALG;
            end else begin
              st <= IDLE;
              if (!cal_res) swap <= !swap;
            end
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid && !rd_ack |=> result_valid); // R5
  AST_QUIET_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> !gate_t1 && !gate_t2); // R10
  AST_ERR_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !busy && !result_valid); // R8
  AST_SWAP_ON_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !(result_valid && rd_ack) |=> $stable(swap)); // R6
  AST_CAL_GATES_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cal_res && !result_valid |-> gate_t1 == gate_t2); // R7
  AST_WAIT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(result_valid) |-> $past(ip_ready)); // R5
endmodule

// File: tb/tdc_frontend_ctl_test.sv
module tdc_frontend_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 6;

  logic clk = 0, rst_n = 0;
  logic ev_a = 0, ev_b = 0, cal_req = 0, ip_ready = 0, rd_ack = 0;
  logic gate_t1, gate_t2, swap, cal_res, cal_long, busy, result_valid, err;
  logic [CW-1:0] coarse;

  int nchk = 0, nfail = 0;
  bit exp_swap = 0;

  tdc_frontend_ctl #(.CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .ev_a(ev_a), .ev_b(ev_b), .cal_req(cal_req),
    .ip_ready(ip_ready), .rd_ack(rd_ack), .gate_t1(gate_t1), .gate_t2(gate_t2),
    .coarse(coarse), .swap(swap), .cal_res(cal_res), .cal_long(cal_long),
    .busy(busy), .result_valid(result_valid), .err(err));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int exp_open_samples(input int ph);
    return (ph < CLK_PERIOD/2) ? 2 : 1;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drv(input bit stop_path, input logic v);
    if (stop_path ^ exp_swap) ev_b = v; else ev_a = v;
  endtask

  task automatic meas(input int d, input int ps, input int pp, input bit poke);
    int c1, c2;
    fork
      begin
        @(posedge clk); #(ps);
        drv(0, 1'b1); #1;
        chk(gate_t1 === 1'b1, "R2 start window opens", gate_t1, 1);
        c1 = 0;
        for (int i = 0; i < 8; i++) begin
          @(negedge clk);
          if (gate_t1) c1++; else break;
        end
        chk(c1 == exp_open_samples(ps), "R2 start window closes on second edge", c1, exp_open_samples(ps));
      end
      begin
        @(posedge clk);
        repeat (d) @(posedge clk);
        #(pp);
        drv(1, 1'b1); #1;
        chk(gate_t2 === 1'b1, "R3 stop window opens", gate_t2, 1);
        c2 = 0;
        for (int i = 0; i < 8; i++) begin
          @(negedge clk);
          if (gate_t2) c2++; else break;
        end
        chk(c2 == exp_open_samples(pp), "R3 stop window closes on second edge", c2, exp_open_samples(pp));
      end
    join
    repeat (3) @(negedge clk);
    chk(!result_valid, "R5 no result before ip_ready", result_valid, 0);
    ip_ready = 1;
    @(negedge clk);
    ip_ready = 0;
    chk(result_valid, "R5 result after ip_ready", result_valid, 1);
    chk(coarse == d, "R4 coarse count", coarse, d);
    chk(swap == exp_swap, "R6 swap reported", swap, exp_swap);
    chk(!err && !cal_res, "R8 err cleared on new measurement", err, 0);
    drv(0, 1'b0); drv(1, 1'b0);
    if (poke) begin
      @(negedge clk);
      drv(0, 1'b1); #1;
      chk(!gate_t1, "R10 start ignored while held", gate_t1, 0);
      @(negedge clk);
      chk(coarse == d && result_valid && !gate_t1, "R10 result untouched", coarse, d);
      drv(0, 1'b0);
    end
    @(negedge clk);
    chk(result_valid, "R5 result held until read", result_valid, 1);
    rd_ack = 1;
    @(negedge clk);
    rd_ack = 0;
    exp_swap = !exp_swap;
    chk(!busy && !result_valid, "R5 read releases result", busy, 0);
    chk(swap == exp_swap, "R6 swap toggles after read", swap, exp_swap);
    @(negedge clk);
  endtask

  task automatic overflow_run(input int d, input bit give_stop);
    @(posedge clk); #2;
    drv(0, 1'b1);
    if (give_stop) begin
      repeat (d) @(posedge clk);
      #2 drv(1, 1'b1);
    end
    @(negedge clk); @(negedge clk);
    for (int i = 0; i < 200; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
    chk(err && !busy && !result_valid, "R8 overflow sets err and idles", err, 1);
    chk(swap == exp_swap, "R8 no swap on error", swap, exp_swap);
    drv(0, 1'b0); drv(1, 1'b0);
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    nfail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !result_valid && !err && !swap && !cal_res && !gate_t1 && !gate_t2,
        "R1 reset state", {busy, result_valid, err, swap, gate_t1, gate_t2}, 0);

    meas(0, 2, 2, 0);
    meas(3, 7, 2, 1);
    meas(5, 3, 8, 0);
    meas(CW'(1) * 0 + (1 << CW) - 1, 2, 2, 0); // R9 boundary
    chk(exp_swap == 0, "R9 boundary measurement completed", exp_swap, 0);

    overflow_run((1 << CW), 1);  // R8 late stop
    overflow_run(0, 0);          // R8 missing stop

    for (int k = 0; k < 12; k++) begin
      int d, ps, pp;
      d  = $urandom_range(0, 40);
      ps = ($urandom_range(0, 1) != 0) ? $urandom_range(1, 3) : $urandom_range(6, 8);
      pp = ($urandom_range(0, 1) != 0) ? $urandom_range(1, 3) : $urandom_range(6, 8);
      if (d == 0 && pp < ps) pp = ps;
      meas(d, ps, pp, k[0]);
    end

    // R7 calibration sequence
    ip_ready = 1;
    cal_req = 1;
    @(negedge clk);
    cal_req = 0;
    chk(gate_t1 && gate_t2 && cal_res && busy, "R7 short window on both gates", {gate_t1, gate_t2}, 3);
    @(negedge clk);
    chk(!gate_t1 && !gate_t2, "R7 short window lasts one period", {gate_t1, gate_t2}, 0);
    @(negedge clk);
    chk(result_valid && cal_res && !cal_long, "R7 first step result", {cal_res, cal_long}, 2);
    rd_ack = 1;
    @(negedge clk);
    rd_ack = 0;
    chk(gate_t1 && gate_t2, "R7 long window first period", {gate_t1, gate_t2}, 3);
    @(negedge clk);
    chk(gate_t1 && gate_t2, "R7 long window second period", {gate_t1, gate_t2}, 3);
    @(negedge clk);
    chk(!gate_t1 && !gate_t2, "R7 long window ends after two periods", {gate_t1, gate_t2}, 0);
    @(negedge clk);
    chk(result_valid && cal_res && cal_long, "R7 second step result", {cal_res, cal_long}, 3);
    rd_ack = 1;
    @(negedge clk);
    rd_ack = 0;
    ip_ready = 0;
    chk(!busy && swap == exp_swap, "R7 calibration leaves swap", swap, exp_swap);
    @(negedge clk);

    meas(4, 1, 6, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule